// File: doc/BRIEF.md
# Idle Demotion Timer with Epoch Slack Guard

This block works next to a memory power-limiting controller. For every memory device it watches the power level the controller reports and counts the cycles the device has spent idle at that level. Once that count reaches the threshold for the level, the block raises a request asking the controller to drop the device one level deeper. There is one threshold for each level that can still be demoted, and all devices share them.

A second part keeps a signed account of performance slack. For every access, the controller reports two overheads: the one actually paid and the one a plain power-limited reference policy would have paid. Each such pair takes the excess (actual minus reference) out of the account. A negative excess puts slack back in. When the account reaches zero or goes below it, energy saving stops for the rest of the epoch. Demotion requests are then masked, and a one-cycle restore request tells the controller to return the devices to the reference policy's levels.

Epochs have a fixed length in cycles. At every boundary the account is refilled with a programmable fair share plus any positive leftover, and saving is switched on again. The shared thresholds are retuned at each epoch end: they are halved when slack is left over and doubled when it ran out. Each threshold is held between its default value and a fixed multiple of that default.

Top module: `idle_demote_guard`

## Requirements
- R1: During and straight after reset, `demote_req` is all zero, `conserve_en` is 1, `restore_req` is 0 and `ovh_ready` is 1.
- R2: The level encoding on `dev_level` bits [2d+1:2d] for device d is: 0 active, 1 standby, 2 nap, 3 deepest. `demote_req[d]` goes high exactly T clock edges after the edge that cleared the device's idle count, where T is the current threshold for its level. It then stays high until the count is cleared again. The default thresholds are `TH_AS` (level 0), `TH_SN` (level 1) and `TH_NP` (level 2).
- R3: An access strobe on `dev_access[d]` clears that device's idle count, so `demote_req[d]` is low in the cycle after the strobe.
- R4: A change of `dev_level` for a device clears its idle count, so `demote_req[d]` is low in the cycle after the change, and counting restarts against the new level's threshold.
- R5: A device at level 3 never gets a demotion request.
- R6: Each accepted overhead pair changes the slack account by reference minus actual. If the result is zero or below on a cycle that is not an epoch boundary, `conserve_en` falls after that edge and `restore_req` is high for exactly that one cycle.
- R7: While `conserve_en` is low, every bit of `demote_req` is low.
- R8: An epoch boundary occurs every `EPOCH_LEN` cycles. The first cycle after reset is also a refill, with a leftover of zero. At a boundary the account becomes max(leftover, 0) + `fair_share` and `conserve_en` returns to 1.
- R9: At an epoch end where the account (after that cycle's access) is zero or below, every threshold doubles, capped at `TH_SCALE` times its default.
- R10: At an epoch end where the account is positive, every threshold halves, but never below its default.
- R11: The account saturates at +(2^(SLACK_W-1))-1 and -(2^(SLACK_W-1)). It does not wrap.
- R12: The overhead channel is valid/ready. `ovh_ready` is always 1, so the channel never applies back-pressure, and each cycle with `ovh_valid` high accounts for one pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_access | input | NDEV | Per-device access strobe |
| dev_level | input | 2*NDEV | Per-device current power level, 2 bits each |
| ovh_valid | input | 1 | Overhead pair valid |
| ovh_ready | output | 1 | Overhead pair ready (always 1) |
| ovh_actual | input | OVH_W | Overhead actually paid by this access |
| ovh_ref | input | OVH_W | Overhead the reference policy would have paid |
| fair_share | input | SLACK_W-1 | Slack granted to each epoch |
| demote_req | output | NDEV | Per-device one-level demotion request |
| conserve_en | output | 1 | Energy saving allowed in this epoch |
| restore_req | output | 1 | One-cycle request to return to reference levels |

## Verification
The bench builds the block with three devices, a 400-cycle epoch, default thresholds of 4, 7 and 12 cycles, a clamp factor of 4, a 10-bit slack account and 8-bit overheads. With these values, the upper clamp on a threshold is reached after two exhausted epochs and the lower clamp after two generous ones. Both limits of the account can be reached with a handful of overhead pairs, so saturation, carry of leftover slack and retuning in both directions all fit inside a few thousand cycles. Directed sequences pin the exact demotion delay at each retuned threshold. Random epochs are then checked every cycle against a model kept in the bench.

// File: rtl/dgd_pkg.sv
package dgd_pkg;
  typedef enum logic [1:0] {
    LVL_ACT  = 2'd0,
    LVL_STBY = 2'd1,
    LVL_NAP  = 2'd2,
    LVL_DEEP = 2'd3
  } lvl_e;

  localparam int NSTEP = 3;  // levels that can still be demoted
endpackage

// File: rtl/dgd_idle_timer.sv
module dgd_idle_timer
  import dgd_pkg::*;
#(
  parameter int TH_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    access,
  input  logic [1:0]              lvl_in,
  input  logic [NSTEP*TH_W-1:0]   thr_all,
  input  logic                    enable,
  output logic                    demote
);
  lvl_e            lvl_q;
  lvl_e            lvl_now;
  logic [TH_W-1:0] cnt_q;
  logic [TH_W-1:0] thr_sel;
  logic            deep;

  assign lvl_now = lvl_e'(lvl_in);
  assign deep    = (lvl_q == LVL_DEEP);

  always_comb begin
    case (lvl_q)
      LVL_ACT:  thr_sel = thr_all[0 +: TH_W];
      LVL_STBY: thr_sel = thr_all[TH_W +: TH_W];
      LVL_NAP:  thr_sel = thr_all[2*TH_W +: TH_W];
      default:  thr_sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= LVL_ACT;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_now;
      if (access || (lvl_now != lvl_q)) begin
        cnt_q <= '0;
      end else if (!deep && (cnt_q < thr_sel)) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign demote = enable && !deep && (cnt_q >= thr_sel);
endmodule

// File: rtl/dgd_thr_tune.sv
module dgd_thr_tune
  import dgd_pkg::*;
#(
  parameter int TH_W     = 16,
  parameter int DEF_AS   = 14,
  parameter int DEF_SN   = 69,
  parameter int DEF_NP   = 3333,
  parameter int TH_SCALE = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tune_up,
  input  logic                  tune_dn,
  output logic [NSTEP*TH_W-1:0] thr_all
);
  for (genvar i = 0; i < NSTEP; i++) begin : g_lvl
    localparam int DEF = (i == 0) ? DEF_AS : ((i == 1) ? DEF_SN : DEF_NP);
    localparam logic [TH_W:0] LO = (TH_W+1)'(DEF);
    localparam logic [TH_W:0] HI = (TH_W+1)'(DEF * TH_SCALE);

    logic [TH_W-1:0] thr_q;
    logic [TH_W:0]   dbl;
    logic [TH_W:0]   hlf;

    assign dbl = {thr_q, 1'b0};
    assign hlf = {2'b00, thr_q[TH_W-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        thr_q <= LO[TH_W-1:0];
      end else if (tune_up) begin
        thr_q <= (dbl > HI) ? HI[TH_W-1:0] : dbl[TH_W-1:0];
      end else if (tune_dn) begin
        thr_q <= (hlf < LO) ? LO[TH_W-1:0] : hlf[TH_W-1:0];
      end
    end

    assign thr_all[i*TH_W +: TH_W] = thr_q;
  end
endmodule

// File: rtl/dgd_slack_epoch.sv
module dgd_slack_epoch #(
  parameter int EPOCH_LEN = 5000000,
  parameter int SLACK_W   = 24,
  parameter int OVH_W     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ovh_take,
  input  logic [OVH_W-1:0]   ovh_actual,
  input  logic [OVH_W-1:0]   ovh_ref,
  input  logic [SLACK_W-2:0] fair_share,
  output logic               conserve_en,
  output logic               restore_req,
  output logic               tune_up,
  output logic               tune_dn
);
  localparam int EP_W = (EPOCH_LEN > 1) ? $clog2(EPOCH_LEN) : 1;
  localparam logic [EP_W-1:0] EP_LAST = EP_W'(EPOCH_LEN - 1);
  localparam int WW = ((SLACK_W > OVH_W + 1) ? SLACK_W : OVH_W + 1) + 2;
  localparam logic signed [WW-1:0] S_MAX = WW'((longint'(1) << (SLACK_W - 1)) - longint'(1));
  localparam logic signed [WW-1:0] S_MIN = -S_MAX - WW'(1);

  logic signed [SLACK_W-1:0] slack_q;
  logic [EP_W-1:0]           ep_q;
  logic                      start_q;
  logic                      cons_q;
  logic                      rest_q;

  logic signed [WW-1:0]      slk_w;
  logic signed [WW-1:0]      dlt_w;
  logic signed [WW-1:0]      aft_w;
  logic signed [WW-1:0]      fill_w;
  logic signed [SLACK_W-1:0] aft_s;
  logic signed [SLACK_W-1:0] fill_s;
  logic                      aft_pos;
  logic                      epoch_end;
  logic                      boundary;

  function automatic logic signed [SLACK_W-1:0] clip(input logic signed [WW-1:0] v);
    if (v > S_MAX)      clip = S_MAX[SLACK_W-1:0];
    else if (v < S_MIN) clip = S_MIN[SLACK_W-1:0];
    else                clip = v[SLACK_W-1:0];
  endfunction

  assign slk_w = {{(WW-SLACK_W){slack_q[SLACK_W-1]}}, slack_q};
  assign dlt_w = ovh_take ? ({{(WW-OVH_W){1'b0}}, ovh_actual} - {{(WW-OVH_W){1'b0}}, ovh_ref})
                          : '0;
  assign aft_w   = slk_w - dlt_w;
  assign aft_s   = clip(aft_w);
  assign aft_pos = (aft_s[SLACK_W-1] == 1'b0) && (aft_s != '0);
  assign fill_w  = (aft_pos ? {{(WW-SLACK_W){1'b0}}, aft_s} : '0)
                 + {{(WW-SLACK_W+1){1'b0}}, fair_share};
  assign fill_s  = clip(fill_w);

  assign epoch_end = (ep_q == EP_LAST);
  assign boundary  = start_q || epoch_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slack_q <= '0;
      ep_q    <= '0;
      start_q <= 1'b1;
      cons_q  <= 1'b1;
      rest_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      ep_q    <= epoch_end ? '0 : ep_q + 1'b1;
      if (boundary) begin
        slack_q <= fill_s;
        cons_q  <= 1'b1;
        rest_q  <= 1'b0;
      end else begin
        slack_q <= aft_s;
        rest_q  <= cons_q && !aft_pos;
        if (!aft_pos) cons_q <= 1'b0;
      end
    end
  end

  assign tune_up     = epoch_end && !start_q && !aft_pos;
  assign tune_dn     = epoch_end && !start_q && aft_pos;
  assign conserve_en = cons_q;
  assign restore_req = rest_q;
endmodule

// File: rtl/idle_demote_guard.sv
module idle_demote_guard
  import dgd_pkg::*;
#(
  parameter int NDEV      = 4,
  parameter int EPOCH_LEN = 5000000,
  parameter int TH_AS     = 14,
  parameter int TH_SN     = 69,
  parameter int TH_NP     = 3333,
  parameter int TH_SCALE  = 16,
  parameter int SLACK_W   = 24,
  parameter int OVH_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NDEV-1:0]      dev_access,
  input  logic [2*NDEV-1:0]    dev_level,
  input  logic                 ovh_valid,
  output logic                 ovh_ready,
  input  logic [OVH_W-1:0]     ovh_actual,
  input  logic [OVH_W-1:0]     ovh_ref,
  input  logic [SLACK_W-2:0]   fair_share,
  output logic [NDEV-1:0]      demote_req,
  output logic                 conserve_en,
  output logic                 restore_req
);
  localparam int TH_BIG  = (TH_AS > TH_SN) ? ((TH_AS > TH_NP) ? TH_AS : TH_NP)
                                           : ((TH_SN > TH_NP) ? TH_SN : TH_NP);
  localparam int TH_W    = $clog2(TH_BIG * TH_SCALE + 1);

  logic [NSTEP*TH_W-1:0] thr_all;
  logic                  tune_up;
  logic                  tune_dn;
  logic                  ovh_take;

  assign ovh_ready = 1'b1;
  assign ovh_take  = ovh_valid && ovh_ready;

  dgd_slack_epoch #(
    .EPOCH_LEN (EPOCH_LEN),
    .SLACK_W   (SLACK_W),
    .OVH_W     (OVH_W)
  ) u_slack (
    .clk         (clk),
    .rst_n       (rst_n),
    .ovh_take    (ovh_take),
    .ovh_actual  (ovh_actual),
    .ovh_ref     (ovh_ref),
    .fair_share  (fair_share),
    .conserve_en (conserve_en),
    .restore_req (restore_req),
    .tune_up     (tune_up),
    .tune_dn     (tune_dn)
  );

  dgd_thr_tune #(
    .TH_W     (TH_W),
    .DEF_AS   (TH_AS),
    .DEF_SN   (TH_SN),
    .DEF_NP   (TH_NP),
    .TH_SCALE (TH_SCALE)
  ) u_tune (
    .clk     (clk),
    .rst_n   (rst_n),
    .tune_up (tune_up),
    .tune_dn (tune_dn),
    .thr_all (thr_all)
  );

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    dgd_idle_timer #(
      .TH_W (TH_W)
    ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .access  (dev_access[d]),
      .lvl_in  (dev_level[2*d +: 2]),
      .thr_all (thr_all),
      .enable  (conserve_en),
      .demote  (demote_req[d])
    );
  end
endmodule

// File: rtl/idle_demote_guard_chk.sv
module idle_demote_guard_chk #(
  parameter int NDEV = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NDEV-1:0]   dev_access,
  input logic [2*NDEV-1:0] dev_level,
  input logic [NDEV-1:0]   demote_req,
  input logic              conserve_en,
  input logic              restore_req
);
  AST_DEMOTE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|demote_req) |-> conserve_en); // R7

  AST_RESTORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    restore_req |=> !restore_req); // R6

  AST_RESTORE_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    restore_req |-> (!conserve_en && $past(conserve_en))); // R6

  for (genvar d = 0; d < NDEV; d++) begin : g_chk
    AST_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      dev_access[d] |=> !demote_req[d]); // R3

    AST_LEVEL_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_level[2*d +: 2] != $past(dev_level[2*d +: 2])) |=> !demote_req[d]); // R4

    AST_DEEP_NO_DEMOTE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dev_level[2*d +: 2]) == 2'd3) |-> !demote_req[d]); // R5
  end
endmodule

bind idle_demote_guard idle_demote_guard_chk #(.NDEV(NDEV)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dev_access  (dev_access),
  .dev_level   (dev_level),
  .demote_req  (demote_req),
  .conserve_en (conserve_en),
  .restore_req (restore_req)
);

// File: tb/test_idle_demote_guard.sv
`timescale 1ns/1ps
module test_idle_demote_guard;
  localparam int NDEV = 3;
  localparam int EL   = 400;
  localparam int SW   = 10;
  localparam int OW   = 8;
  localparam int SMAX = (1 << (SW-1)) - 1;
  localparam int SMIN = -(1 << (SW-1));
  localparam int LO [3] = '{4, 7, 12};
  localparam int HI [3] = '{16, 28, 48};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NDEV-1:0]   dev_access = '0;
  logic [2*NDEV-1:0] dev_level = '0;
  logic              ovh_valid = 1'b0;
  logic              ovh_ready;
  logic [OW-1:0]     ovh_actual = '0;
  logic [OW-1:0]     ovh_ref = '0;
  logic [SW-2:0]     fair_share = 9'd200;
  logic [NDEV-1:0]   demote_req;
  logic              conserve_en;
  logic              restore_req;

  always #5 clk = ~clk;

  idle_demote_guard #(
    .NDEV(NDEV), .EPOCH_LEN(EL), .TH_AS(4), .TH_SN(7), .TH_NP(12),
    .TH_SCALE(4), .SLACK_W(SW), .OVH_W(OW)
  ) i_idle_demote_guard (
    .clk(clk), .rst_n(rst_n), .dev_access(dev_access), .dev_level(dev_level),
    .ovh_valid(ovh_valid), .ovh_ready(ovh_ready), .ovh_actual(ovh_actual),
    .ovh_ref(ovh_ref), .fair_share(fair_share), .demote_req(demote_req),
    .conserve_en(conserve_en), .restore_req(restore_req)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit run_cmp = 1'b0;

  // bench model state
  int m_cnt [NDEV];
  int m_prev [NDEV];
  int m_thr [3];
  int m_slack, m_ep, m_dl, m_sa, m_lv, m_td;
  bit m_start, m_cons, m_rest, m_pos, m_bnd;

  function automatic int clip(input int v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  function automatic bit exp_demote(input int d);
    if (!m_cons || m_prev[d] == 3) return 1'b0;
    return m_cnt[d] >= m_thr[m_prev[d]];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ep = 0; m_start = 1'b1; m_slack = 0; m_cons = 1'b1; m_rest = 1'b0;
      for (int d = 0; d < NDEV; d++) begin m_cnt[d] = 0; m_prev[d] = 0; end
      for (int i = 0; i < 3; i++) m_thr[i] = LO[i];
    end else begin
      for (int d = 0; d < NDEV; d++) begin
        m_lv = int'(dev_level[2*d +: 2]);
        m_td = (m_prev[d] == 3) ? 0 : m_thr[m_prev[d]];
        if (dev_access[d] || m_lv != m_prev[d]) m_cnt[d] = 0;
        else if (m_prev[d] != 3 && m_cnt[d] < m_td) m_cnt[d]++;
        m_prev[d] = m_lv;
      end
      m_dl  = ovh_valid ? (int'(ovh_actual) - int'(ovh_ref)) : 0;
      m_sa  = clip(m_slack - m_dl);
      m_pos = (m_sa > 0);
      m_bnd = m_start || (m_ep == EL-1);
      if (m_ep == EL-1 && !m_start)
        for (int i = 0; i < 3; i++)
          m_thr[i] = m_pos ? ((m_thr[i]/2 < LO[i]) ? LO[i] : m_thr[i]/2)
                           : ((m_thr[i]*2 > HI[i]) ? HI[i] : m_thr[i]*2);
      if (m_bnd) begin
        m_slack = clip((m_pos ? m_sa : 0) + int'(fair_share));
        m_cons = 1'b1; m_rest = 1'b0;
      end else begin
        m_slack = m_sa;
        m_rest = m_cons && !m_pos;
        if (!m_pos) m_cons = 1'b0;
      end
      m_ep = (m_ep == EL-1) ? 0 : m_ep + 1;
      m_start = 1'b0;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && run_cmp && !done) begin
      for (int d = 0; d < NDEV; d++)
        chk($sformatf("R2 demote dev%0d", d), int'(demote_req[d]), int'(exp_demote(d)));
      chk("R6 conserve_en", int'(conserve_en), int'(m_cons));
      chk("R6 restore_req", int'(restore_req), int'(m_rest));
    end
  end

  task automatic wait_ep(input int n);
    do @(negedge clk); while (m_ep != n);
  endtask

  task automatic drive_ovh(input int a, input int r);
    ovh_valid = 1'b1; ovh_actual = OW'(a); ovh_ref = OW'(r);
    @(negedge clk);
    ovh_valid = 1'b0;
  endtask

  task automatic time_demote(input int d, input int t, input string tag);
    dev_access[d] = 1'b1;
    @(negedge clk);
    dev_access[d] = 1'b0;
    repeat (t-1) @(negedge clk);
    chk({tag, " before threshold"}, int'(demote_req[d]), 0);
    @(negedge clk);
    chk({tag, " at threshold"}, int'(demote_req[d]), 1);
  endtask

  initial begin
    int seed;
    seed = 32'd7;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R1 demote in reset", int'(demote_req), 0);
    chk("R1 conserve in reset", int'(conserve_en), 1);
    chk("R1 restore in reset", int'(restore_req), 0);
    chk("R12 ready", int'(ovh_ready), 1);
    rst_n = 1'b1;
    run_cmp = 1'b1;
    @(negedge clk);
    chk("R1 after reset", int'(demote_req), 0);
    @(negedge clk);

    time_demote(0, 4, "R2 level0");
    dev_access[0] = 1'b1; @(negedge clk); dev_access[0] = 1'b0;
    chk("R3 access clears", int'(demote_req[0]), 0);
    repeat (5) @(negedge clk);
    chk("R2 held", int'(demote_req[0]), 1);
    dev_level[1:0] = 2'd1; @(negedge clk);
    chk("R4 level change clears", int'(demote_req[0]), 0);
    repeat (6) @(negedge clk);
    chk("R4 new threshold early", int'(demote_req[0]), 0);
    @(negedge clk);
    chk("R4 new threshold", int'(demote_req[0]), 1);
    dev_level[3:2] = 2'd3;
    repeat (30) @(negedge clk);
    chk("R5 deepest", int'(demote_req[1]), 0);

    wait_ep(100);
    repeat (4) drive_ovh(0, 255);
    drive_ovh(255, 0);
    drive_ovh(255, 0);
    chk("R11 saturated account", int'(conserve_en), 1);
    chk("R2 dev2 idle", int'(demote_req[2]), 1);
    drive_ovh(1, 0);
    chk("R6 conserve off", int'(conserve_en), 0);
    chk("R6 restore pulse", int'(restore_req), 1);
    @(negedge clk);
    chk("R6 restore single", int'(restore_req), 0);
    chk("R7 masked", int'(demote_req[2]), 0);

    wait_ep(3);
    chk("R8 re-enabled", int'(conserve_en), 1);
    time_demote(0, 14, "R9 doubled");
    wait_ep(3);
    time_demote(0, 7, "R10 halved");
    drive_ovh(255, 0);
    drive_ovh(144, 0);
    chk("R8 leftover carried", int'(conserve_en), 1);
    drive_ovh(1, 0);
    chk("R6 exhausted", int'(conserve_en), 0);
    wait_ep(3); drive_ovh(255, 0);
    wait_ep(3); drive_ovh(255, 0);
    wait_ep(3);
    time_demote(0, 28, "R9 upper clamp");
    wait_ep(3); wait_ep(3); wait_ep(3);
    time_demote(0, 7, "R10 lower clamp");

    for (int e = 0; e < 6; e++) begin
      fair_share = (SW-1)'($urandom % 512);
      for (int c = 0; c < EL; c++) begin
        for (int d = 0; d < NDEV; d++) begin
          dev_access[d] = ($urandom % 6) == 0;
          if (($urandom % 40) == 0) dev_level[2*d +: 2] = 2'($urandom % 4);
        end
        ovh_valid  = ($urandom % 3) == 0;
        ovh_actual = OW'($urandom % 256);
        ovh_ref    = (e % 2 == 0) ? OW'($urandom % 256) : (ovh_actual >> 2);
        if (c == EL/2 && e == 3) ovh_actual = 8'd255;
        @(negedge clk);
      end
    end
    dev_access = '0; ovh_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule